// File: doc/BRIEF.md
# Secure peripheral protection configuration bank

This block is the secure-side register bank that programs a set of peripheral protection controllers. It holds, for every controller, one non-secure flag per peripheral port and one secure-privilege flag per port. The controllers are two internal APB controllers, four APB expansion controllers and four AHB expansion controllers. A 32-bit memory-mapped access port reads and writes these flags. The non-secure flags of every port drive dedicated output pins, which feed the protection controllers directly.

The bank also holds two small configuration fields, each with its own output pin. One is a single-bit secure response setting. The other is a two-bit setting for non-secure callable regions. Each register group occupies a 16-byte-aligned window, so address bits [3:2] select the controller within a group. Stored values are masked to the port count of their controller. Only full-word writes take effect. Byte and halfword reads return the addressed byte lanes of the word.

Top module: `sec_ppc_cfg`

## Requirements
- R1: While `rst_n` is low, and after it is released, every non-secure flag, every privilege flag, `resp_cfg` and `callable_cfg` read as zero.
- R2: A word write to offset 0x60+4k (AHB expansion k), 0x70+4k (internal APB k) or 0x80+4k (APB expansion k) stores the non-secure flags of that controller. Bit p of the stored value drives port p on its output: `ahb_exp_ns[k*EXP_PORTS+p]`, `apb_exp_ns[k*EXP_PORTS+p]`, or `apb_int0_ns[p]` / `apb_int1_ns[p]`. A read of the offset returns the stored value.
- R3: A word write to offset 0xA0+4k (AHB expansion), 0xB0+4k (internal APB) or 0xC0+4k (APB expansion) stores the secure-privilege flags of controller k. A read returns them. These writes leave the non-secure outputs unchanged.
- R4: Every stored flag value is masked to its controller's port count: `INT0_PORTS`, `INT1_PORTS`, or `EXP_PORTS` for the expansion controllers. Bits above the port count read as zero.
- R5: Offsets 0x50 and 0x90 always read zero. Writes to them change no state.
- R6: Offset 0x10 holds a 1-bit secure response setting taken from write data bit 0. It is driven on `resp_cfg` and reads back in bit 0.
- R7: Offset 0x14 holds a 2-bit non-secure callable setting taken from write data bits [1:0]. It is driven on `callable_cfg` and reads back in bits [1:0].
- R8: Only writes with `bus_size`=2 (word) and `bus_addr[1:0]`=0 take effect. Byte (`bus_size`=0) and halfword (`bus_size`=1) writes are ignored.
- R9: A byte read returns word bits [8a+7:8a], where a=`bus_addr[1:0]`, zero-extended. A halfword read returns the 16 bits starting at that byte, zero-extended.
- R10: Unmapped offsets read zero and ignore writes. This includes internal APB index 2 and 3 (0x78, 0x7C, 0xB8, 0xBC).
- R11: A read request (`bus_sel` high, `bus_wr` low) at a clock edge produces `bus_rvalid` high with the data on `bus_rdata` after that edge, for exactly one cycle. `bus_rvalid` is low after any edge without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| resp_cfg | output | 1 | Secure response setting |
| callable_cfg | output | 2 | Non-secure callable setting |
| apb_int0_ns | output | INT0_PORTS | Non-secure flags, internal APB controller 0 |
| apb_int1_ns | output | INT1_PORTS | Non-secure flags, internal APB controller 1 |
| apb_exp_ns | output | 4*EXP_PORTS | Non-secure flags, APB expansion controllers |
| ahb_exp_ns | output | 4*EXP_PORTS | Non-secure flags, AHB expansion controllers |

## Verification
Several properties are checked on every cycle: the read-valid timing, the zeroing on reset, the stability of all outputs across byte and halfword writes, the capture of both configuration fields on word writes, and the zero returned from the two reserved slots. The bench scenarios are needed for the rest. They show that the index decode places each controller's flags on the right output slice, and that masking holds at each port count. They also show byte-lane selection on narrow reads, and that privilege writes and unmapped offsets leave the non-secure pins untouched.

// File: rtl/sec_ppc_cfg.sv
module sec_ppc_cfg #(
  parameter int INT0_PORTS = 14,
  parameter int INT1_PORTS = 8,
  parameter int EXP_PORTS  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [1:0]             bus_size,
  input  logic [11:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  output logic                   resp_cfg,
  output logic [1:0]             callable_cfg,
  output logic [INT0_PORTS-1:0]  apb_int0_ns,
  output logic [INT1_PORTS-1:0]  apb_int1_ns,
  output logic [4*EXP_PORTS-1:0] apb_exp_ns,
  output logic [4*EXP_PORTS-1:0] ahb_exp_ns
);
  localparam logic [63:0] M0W = (64'd1 << INT0_PORTS) - 64'd1;
  localparam logic [63:0] M1W = (64'd1 << INT1_PORTS) - 64'd1;
  localparam logic [63:0] MXW = (64'd1 << EXP_PORTS) - 64'd1;
  localparam logic [31:0] M0 = M0W[31:0];
  localparam logic [31:0] M1 = M1W[31:0];
  localparam logic [31:0] MX = MXW[31:0];

  logic [31:0] ns_i [2], sp_i [2];
  logic [31:0] ns_ax[4], sp_ax[4];
  logic [31:0] ns_hx[4], sp_hx[4];

  logic [7:0]  grp;
  logic [1:0]  idx;
  logic        wen, ren;
  logic [31:0] imask, word, lane;

  assign grp   = bus_addr[11:4];
  assign idx   = bus_addr[3:2];
  assign wen   = bus_sel && bus_wr && bus_size == 2'd2 && bus_addr[1:0] == 2'd0;
  assign ren   = bus_sel && !bus_wr;
  assign imask = idx[0] ? M1 : M0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_cfg     <= 1'b0;
      callable_cfg <= 2'd0;
      for (int i = 0; i < 2; i++) begin
        ns_i[i] <= '0;
        sp_i[i] <= '0;
      end
      for (int i = 0; i < 4; i++) begin
        ns_ax[i] <= '0;
        sp_ax[i] <= '0;
        ns_hx[i] <= '0;
        sp_hx[i] <= '0;
      end
    end else if (wen) begin
      case (grp)
        8'h01: begin
          if (idx == 2'd0) resp_cfg <= bus_wdata[0];
          if (idx == 2'd1) callable_cfg <= bus_wdata[1:0];
        end
        8'h06: ns_hx[idx] <= bus_wdata & MX;
        8'h07: if (!idx[1]) ns_i[idx[0]] <= bus_wdata & imask;
        8'h08: ns_ax[idx] <= bus_wdata & MX;
        8'h0A: sp_hx[idx] <= bus_wdata & MX;
        8'h0B: if (!idx[1]) sp_i[idx[0]] <= bus_wdata & imask;
        8'h0C: sp_ax[idx] <= bus_wdata & MX;
        default: ;
      endcase
    end
  end

  always_comb begin
    word = '0;
    case (grp)
      8'h01: begin
        if (idx == 2'd0) word = {31'd0, resp_cfg};
        if (idx == 2'd1) word = {30'd0, callable_cfg};
      end
      8'h06: word = ns_hx[idx];
      8'h07: if (!idx[1]) word = ns_i[idx[0]];
      8'h08: word = ns_ax[idx];
      8'h0A: word = sp_hx[idx];
      8'h0B: if (!idx[1]) word = sp_i[idx[0]];
      8'h0C: word = sp_ax[idx];
      default: word = '0;
    endcase
  end

  always_comb begin
    lane = word >> {bus_addr[1:0], 3'b000};
    case (bus_size)
      2'd0:    lane = lane & 32'h0000_00FF;
      2'd1:    lane = lane & 32'h0000_FFFF;
      default: lane = word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= ren;
      if (ren) bus_rdata <= lane;
    end
  end

  assign apb_int0_ns = ns_i[0][INT0_PORTS-1:0];
  assign apb_int1_ns = ns_i[1][INT1_PORTS-1:0];

  for (genvar g = 0; g < 4; g++) begin : g_exp
    assign apb_exp_ns[g*EXP_PORTS +: EXP_PORTS] = ns_ax[g][EXP_PORTS-1:0];
    assign ahb_exp_ns[g*EXP_PORTS +: EXP_PORTS] = ns_hx[g][EXP_PORTS-1:0];
  end
endmodule

// File: rtl/sec_ppc_cfg_chk.sv
module sec_ppc_cfg_chk #(
  parameter int INT0_PORTS = 14,
  parameter int INT1_PORTS = 8,
  parameter int EXP_PORTS  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [1:0]             bus_size,
  input logic [11:0]            bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic                   bus_rvalid,
  input logic                   resp_cfg,
  input logic [1:0]             callable_cfg,
  input logic [INT0_PORTS-1:0]  apb_int0_ns,
  input logic [INT1_PORTS-1:0]  apb_int1_ns,
  input logic [4*EXP_PORTS-1:0] apb_exp_ns,
  input logic [4*EXP_PORTS-1:0] ahb_exp_ns
);
  logic word_wr;
  assign word_wr = bus_sel && bus_wr && bus_size == 2'd2 && bus_addr[1:0] == 2'd0;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!resp_cfg && callable_cfg == 2'd0 && apb_int0_ns == '0 &&
                apb_int1_ns == '0 && apb_exp_ns == '0 && ahb_exp_ns == '0));

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr[11:2] == 10'h014 || bus_addr[11:2] == 10'h024))
      |=> bus_rdata == 32'd0);

  assert_resp_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && bus_addr == 12'h010) |=> resp_cfg == $past(bus_wdata[0]));

  assert_callable_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && bus_addr == 12'h014) |=> callable_cfg == $past(bus_wdata[1:0]));

  assert_narrow_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_size != 2'd2) |=>
      ($stable(resp_cfg) && $stable(callable_cfg) && $stable(apb_int0_ns) &&
       $stable(apb_int1_ns) && $stable(apb_exp_ns) && $stable(ahb_exp_ns)));

  assert_rvalid_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  assert_rvalid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);
endmodule

bind sec_ppc_cfg sec_ppc_cfg_chk #(
  .INT0_PORTS(INT0_PORTS), .INT1_PORTS(INT1_PORTS), .EXP_PORTS(EXP_PORTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .resp_cfg(resp_cfg),
  .callable_cfg(callable_cfg), .apb_int0_ns(apb_int0_ns),
  .apb_int1_ns(apb_int1_ns), .apb_exp_ns(apb_exp_ns), .ahb_exp_ns(ahb_exp_ns)
);

// File: tb/sim_sec_ppc_cfg.sv
module sim_sec_ppc_cfg;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, resp_cfg;
  logic [1:0]  callable_cfg;
  logic [13:0] apb_int0_ns;
  logic [7:0]  apb_int1_ns;
  logic [63:0] apb_exp_ns, ahb_exp_ns;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_ppc_cfg u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .resp_cfg(resp_cfg),
    .callable_cfg(callable_cfg), .apb_int0_ns(apb_int0_ns),
    .apb_int1_ns(apb_int1_ns), .apb_exp_ns(apb_exp_ns), .ahb_exp_ns(ahb_exp_ns)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data whenever the design presents a result
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R11 unexpected rvalid", 64'd1, 64'd0);
      else check(tag_q.pop_front(), {32'd0, bus_rdata}, {32'd0, exp_q.pop_front()});
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag, logic [1:0] sz = 2'd2);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    check("watchdog", 64'd1, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {resp_cfg, callable_cfg, apb_int0_ns, apb_int1_ns}, 64'd0);
    check("R1 reset exp outputs", apb_exp_ns | ahb_exp_ns, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle rvalid", {63'd0, bus_rvalid}, 64'd0);
    rd(12'h010, 32'd0, "R1 resp reg after reset");
    rd(12'hB4, 32'd0, "R1 priv reg after reset");

    wr(12'h070, 32'hFFFF_FFFF);
    check("R2 R4 int0 ns pins", {50'd0, apb_int0_ns}, 64'h3FFF);
    rd(12'h070, 32'h3FFF, "R4 int0 readback masked");
    wr(12'h074, 32'h0001_2345);
    check("R2 R4 int1 ns pins", {56'd0, apb_int1_ns}, 64'h45);
    rd(12'h074, 32'h45, "R4 int1 readback masked");
    wr(12'h068, 32'hABCD_1234);
    check("R2 ahb exp 2 slice", ahb_exp_ns, 64'h0000_1234_0000_0000);
    rd(12'h068, 32'h1234, "R2 R4 ahb exp 2 readback");
    wr(12'h08C, 32'h0000_5A5A);
    check("R2 apb exp 3 slice", apb_exp_ns, 64'h5A5A_0000_0000_0000);

    wr(12'h0A4, 32'hFFFF_0F0F);
    rd(12'h0A4, 32'h0F0F, "R3 R4 ahb exp priv");
    wr(12'h0B4, 32'h0000_0FF0);
    rd(12'h0B4, 32'h00F0, "R3 R4 int1 priv");
    wr(12'h0C0, 32'h0001_0001);
    rd(12'h0C0, 32'h0001, "R3 apb exp priv");
    check("R3 ns pins unchanged", ahb_exp_ns ^ apb_exp_ns, 64'h5A5A_1234_0000_0000);
    check("R3 int ns pins unchanged", {apb_int0_ns, apb_int1_ns}, {42'd0, 14'h3FFF, 8'h45});

    wr(12'h050, 32'hFFFF_FFFF);
    wr(12'h090, 32'hFFFF_FFFF);
    rd(12'h050, 32'd0, "R5 slot 0x50 zero");
    rd(12'h090, 32'd0, "R5 slot 0x90 zero");
    check("R5 pins untouched", ahb_exp_ns, 64'h0000_1234_0000_0000);

    wr(12'h010, 32'h0000_0003);
    check("R6 resp pin", {63'd0, resp_cfg}, 64'd1);
    rd(12'h010, 32'd1, "R6 resp readback");
    wr(12'h014, 32'h0000_0007);
    check("R7 callable pin", {62'd0, callable_cfg}, 64'd3);
    rd(12'h014, 32'd3, "R7 callable readback");

    wr(12'h070, 32'd0, 2'd0);
    wr(12'h010, 32'd0, 2'd1);
    wr(12'h012, 32'd0, 2'd1);
    check("R8 narrow writes ignored int0", {50'd0, apb_int0_ns}, 64'h3FFF);
    check("R8 narrow writes ignored resp", {63'd0, resp_cfg}, 64'd1);
    wr(12'h016, 32'd0, 2'd2);
    check("R8 unaligned word ignored", {62'd0, callable_cfg}, 64'd3);

    rd(12'h069, 32'h12, "R9 byte lane 1", 2'd0);
    rd(12'h070, 32'hFF, "R9 byte lane 0", 2'd0);
    rd(12'h071, 32'h3F, "R9 byte lane 1 int0", 2'd0);
    rd(12'h070, 32'h3FFF, "R9 halfword low", 2'd1);
    rd(12'h0A6, 32'h0, "R9 halfword high", 2'd1);

    wr(12'h078, 32'hFFFF_FFFF);
    wr(12'h0BC, 32'hFFFF_FFFF);
    rd(12'h078, 32'd0, "R10 int index 2 unmapped");
    rd(12'h0BC, 32'd0, "R10 int priv index 3 unmapped");
    rd(12'h200, 32'd0, "R10 far offset");
    check("R10 pins unchanged", {apb_int0_ns, apb_int1_ns}, {42'd0, 14'h3FFF, 8'h45});

    check("R11 queue drained", 64'(exp_q.size()), 64'd0);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", {resp_cfg, callable_cfg, apb_int0_ns, apb_int1_ns}, 64'd0);
    check("R1 reset exp again", apb_exp_ns | ahb_exp_ns, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h0A4, 32'd0, "R1 priv cleared");
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule